// File: doc/BRIEF.md
# Half-Duplex Bidirectional Line Repeater

This block joins a host-side data line and a card-side data line. Both lines are open-drain with pull-ups. Each line is seen by the block as a sensed input plus two drive enables: one pulls the line low and the other turns on a short active pull-up. The block repeats a low in whichever direction it starts. The side that falls first owns the bit. After a programmable delay its low is copied onto the other side. When the owner lets go, the copy is removed, and a timed pull-up boost helps the far line rise.

Both sensed inputs are synchronized before edge detection. While a bit is being repeated, the receiving side cannot start a transfer of its own. If an outside agent still holds a line low after a transfer, the block drives nothing and waits until both lines read high, so the two sides can never lock each other low. An enable input puts the block in its out-of-session condition: the card line is held low, the host line is released and the arbitration returns to rest.

Top module: `line_repeater`

## Requirements
- R1: After reset, and whenever reset is asserted during a transfer, no pull-low and no boost output is active on either side, given the enable is high.
- R2: A host line low first sampled at clock edge 1 asserts `card_pull_low` after edge DELAY_CYC+3 and not before. This count is two synchronizer stages, one detection cycle and DELAY_CYC delay cycles.
- R3: A card line low first sampled at clock edge 1 asserts `host_pull_low` after edge DELAY_CYC+3 and not before.
- R4: When both lines are first sampled low at the same edge, the card side becomes the owner and only `host_pull_low` is asserted.
- R5: While one side owns a bit, lows on the other side are not copied back. The block never asserts both pull-low outputs at once.
- R6: When the owner's line is first sampled high at edge 1, the copied pull-low is removed after edge 3. In the same cycle the boost output on the receiving side turns on, and it stays on for exactly DELAY_CYC cycles.
- R7: An owner low that ends before the delay has elapsed is never copied to the other side.
- R8: If either line is still low when the boost ends, the block drives nothing until both lines read high. It then accepts a new low from either side.
- R9: With `en` low, `card_pull_low` is 1 and `host_pull_low`, `host_boost` and `card_boost` are 0, and lows on the host line are ignored. After `en` returns high, the rising card line starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Session enable; low holds both sides inactive |
| host_in | input | 1 | Sensed level of the host-side line |
| card_in | input | 1 | Sensed level of the card-side line |
| host_pull_low | output | 1 | Pull the host line low |
| host_boost | output | 1 | Short active pull-up on the host line |
| card_pull_low | output | 1 | Pull the card line low |
| card_boost | output | 1 | Short active pull-up on the card line |

## Verification
The checker watches four things on every cycle: the two pull-lows are never on together, the disabled output pattern holds, a boost starts in the cycle its side's pull-low is removed, and each boost lasts exactly DELAY_CYC cycles. Several behaviours can only be shown by the bench's scenarios, because each depends on line history: the exact propagation latency in each direction and the card-side priority on simultaneous falls. The same holds for suppression of short lows, masking of the receiving side, recovery after a line is held low past the boost, and the absence of a spurious transfer on re-enable.

// File: rtl/lrep_pkg.sv
package lrep_pkg;

    localparam int NSIDES = 2;

    typedef enum logic {
        SIDE_HOST = 1'b0,
        SIDE_CARD = 1'b1
    } side_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HOLD,
        ST_BOOST,
        ST_RECOVER
    } arb_state_e;

    typedef struct packed {
        arb_state_e st;
        side_e      owner;
    } arb_t;

    function automatic side_e other_side(input side_e s);
        return (s == SIDE_HOST) ? SIDE_CARD : SIDE_HOST;
    endfunction

endpackage

// File: rtl/lrep_sync.sv
module lrep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= 1'b1;
                else     sh <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= sh[STAGES-1];
    end

    assign level = sh[STAGES-1];
    assign fall  = prev & ~sh[STAGES-1];
endmodule

// File: rtl/lrep_timer.sv
module lrep_timer #(
    parameter int DELAY_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic zero
);
    localparam int CNT_W = $clog2(DELAY_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DELAY_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= RELOAD;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/lrep_arbiter.sv
module lrep_arbiter
    import lrep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [NSIDES-1:0] lvl,
    input  logic [NSIDES-1:0] fall,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [NSIDES-1:0] pull_low,
    output logic [NSIDES-1:0] boost
);
    arb_t cur, nxt;

    always_comb begin
        nxt      = cur;
        tmr_load = 1'b0;
        unique case (cur.st)
            ST_IDLE: begin
                if (fall[SIDE_CARD]) begin
                    nxt.st    = ST_WAIT;
                    nxt.owner = SIDE_CARD;
                    tmr_load  = 1'b1;
                end else if (fall[SIDE_HOST]) begin
                    nxt.st    = ST_WAIT;
                    nxt.owner = SIDE_HOST;
                    tmr_load  = 1'b1;
                end
            end
            ST_WAIT: begin
                if (lvl[cur.owner])  nxt.st = ST_RECOVER;
                else if (tmr_zero)   nxt.st = ST_HOLD;
            end
            ST_HOLD: begin
                if (lvl[cur.owner]) begin
                    nxt.st   = ST_BOOST;
                    tmr_load = 1'b1;
                end
            end
            ST_BOOST: begin
                if (tmr_zero) nxt.st = (&lvl) ? ST_IDLE : ST_RECOVER;
            end
            ST_RECOVER: begin
                if (&lvl) nxt.st = ST_IDLE;
            end
            default: nxt.st = ST_IDLE;
        endcase
        if (!en) begin
            nxt.st   = ST_IDLE;
            tmr_load = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st    <= ST_IDLE;
            cur.owner <= SIDE_HOST;
        end else begin
            cur <= nxt;
        end
    end

    always_comb begin
        pull_low = '0;
        boost    = '0;
        if (!en) begin
            pull_low[SIDE_CARD] = 1'b1;
        end else begin
            pull_low[other_side(cur.owner)] = (cur.st == ST_HOLD);
            boost[other_side(cur.owner)]    = (cur.st == ST_BOOST);
        end
    end
endmodule

// File: rtl/line_repeater.sv
module line_repeater
    import lrep_pkg::*;
#(
    parameter int DELAY_CYC   = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic host_in,
    input  logic card_in,
    output logic host_pull_low,
    output logic host_boost,
    output logic card_pull_low,
    output logic card_boost
);
    logic [NSIDES-1:0] raw_in;
    logic [NSIDES-1:0] lvl;
    logic [NSIDES-1:0] fall;
    logic [NSIDES-1:0] pull_low;
    logic [NSIDES-1:0] boost;
    logic              tmr_load;
    logic              tmr_zero;

    assign raw_in[SIDE_HOST] = host_in;
    assign raw_in[SIDE_CARD] = card_in;

    generate
        for (genvar i = 0; i < NSIDES; i++) begin : g_side
            lrep_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst   (rst),
                .din   (raw_in[i]),
                .level (lvl[i]),
                .fall  (fall[i])
            );
        end
    endgenerate

    lrep_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .zero (tmr_zero)
    );

    lrep_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .lvl      (lvl),
        .fall     (fall),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .pull_low (pull_low),
        .boost    (boost)
    );

    assign host_pull_low = pull_low[SIDE_HOST];
    assign card_pull_low = pull_low[SIDE_CARD];
    assign host_boost    = boost[SIDE_HOST];
    assign card_boost    = boost[SIDE_CARD];
endmodule

// File: rtl/lrep_checker.sv
module lrep_checker #(
    parameter int DELAY_CYC = 20
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic host_pull_low,
    input logic host_boost,
    input logic card_pull_low,
    input logic card_boost
);
    localparam int RW = $clog2(DELAY_CYC + 2) + 1;

    logic [RW-1:0] cb_run, hb_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cb_run <= '0;
            hb_run <= '0;
        end else begin
            cb_run <= card_boost ? cb_run + 1'b1 : '0;
            hb_run <= host_boost ? hb_run + 1'b1 : '0;
        end
    end

    AST_ONE_SIDE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        en |-> !(host_pull_low && card_pull_low)); // R5

    AST_DISABLED_PATTERN: assert property (@(posedge clk) disable iff (rst)
        !en |-> (card_pull_low && !host_pull_low && !host_boost && !card_boost)); // R9

    AST_CARD_BOOST_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $fell(card_pull_low)) |-> card_boost); // R6

    AST_HOST_BOOST_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $fell(host_pull_low)) |-> host_boost); // R6

    AST_CARD_BOOST_LEN: assert property (@(posedge clk) disable iff (rst)
        (en && $fell(card_boost)) |-> (cb_run == RW'(DELAY_CYC))); // R6

    AST_HOST_BOOST_LEN: assert property (@(posedge clk) disable iff (rst)
        (en && $fell(host_boost)) |-> (hb_run == RW'(DELAY_CYC))); // R6

    AST_NO_BOOST_WITH_PULL: assert property (@(posedge clk) disable iff (rst)
        !(card_boost && card_pull_low) && !(host_boost && host_pull_low)); // R6
endmodule

bind line_repeater lrep_checker #(.DELAY_CYC(DELAY_CYC)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .host_pull_low (host_pull_low),
    .host_boost    (host_boost),
    .card_pull_low (card_pull_low),
    .card_boost    (card_boost)
);

// File: tb/line_repeater_tb.sv
module line_repeater_tb;
    localparam int D  = 6;
    localparam int NV = 38;

    typedef struct packed {
        logic       en;
        logic       hd;
        logic       cd;
        logic [7:0] n;
        logic [3:0] exp;   // {host_pull_low, host_boost, card_pull_low, card_boost}
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1,1'b0,1'b0,8'd3, 4'b0000,4'd1},  // R1 idle
        '{1'b1,1'b1,1'b0,8'd8, 4'b0000,4'd2},  // R2 not yet
        '{1'b1,1'b1,1'b0,8'd1, 4'b0010,4'd2},  // R2 copied
        '{1'b1,1'b1,1'b0,8'd5, 4'b0010,4'd5},  // R5 no echo
        '{1'b1,1'b0,1'b0,8'd2, 4'b0010,4'd6},  // R6 still held
        '{1'b1,1'b0,1'b0,8'd1, 4'b0001,4'd6},  // R6 boost on
        '{1'b1,1'b0,1'b0,8'd5, 4'b0001,4'd6},  // R6 boost held
        '{1'b1,1'b0,1'b0,8'd1, 4'b0000,4'd6},  // R6 boost off
        '{1'b1,1'b0,1'b1,8'd8, 4'b0000,4'd3},  // R3 not yet
        '{1'b1,1'b0,1'b1,8'd1, 4'b1000,4'd3},  // R3 copied
        '{1'b1,1'b0,1'b0,8'd3, 4'b0100,4'd6},  // R6 host boost
        '{1'b1,1'b0,1'b0,8'd6, 4'b0000,4'd6},  // R6 boost off
        '{1'b1,1'b1,1'b1,8'd9, 4'b1000,4'd4},  // R4 card wins
        '{1'b1,1'b0,1'b0,8'd3, 4'b0100,4'd6},  // R6
        '{1'b1,1'b0,1'b0,8'd6, 4'b0000,4'd6},  // R6
        '{1'b1,1'b1,1'b0,8'd3, 4'b0000,4'd7},  // R7 short low
        '{1'b1,1'b0,1'b0,8'd6, 4'b0000,4'd7},  // R7 not copied
        '{1'b1,1'b0,1'b0,8'd6, 4'b0000,4'd7},  // R7
        '{1'b1,1'b1,1'b0,8'd9, 4'b0010,4'd8},  // R8 setup
        '{1'b1,1'b1,1'b1,8'd2, 4'b0010,4'd8},  // R8 card also low
        '{1'b1,1'b0,1'b1,8'd3, 4'b0001,4'd8},  // R8 boost
        '{1'b1,1'b0,1'b1,8'd6, 4'b0000,4'd8},  // R8 quiet
        '{1'b1,1'b0,1'b1,8'd10,4'b0000,4'd8},  // R8 no copy of stuck card
        '{1'b1,1'b0,1'b0,8'd3, 4'b0000,4'd8},  // R8 both high
        '{1'b1,1'b1,1'b0,8'd9, 4'b0010,4'd8},  // R8 recovered
        '{1'b1,1'b0,1'b0,8'd9, 4'b0000,4'd6},  // R6
        '{1'b1,1'b0,1'b1,8'd9, 4'b1000,4'd5},  // R5 card owner
        '{1'b1,1'b1,1'b1,8'd4, 4'b1000,4'd5},  // R5 host low masked
        '{1'b1,1'b1,1'b0,8'd3, 4'b0100,4'd5},  // R5
        '{1'b1,1'b1,1'b0,8'd6, 4'b0000,4'd5},  // R5
        '{1'b1,1'b1,1'b0,8'd5, 4'b0000,4'd5},  // R5
        '{1'b1,1'b0,1'b0,8'd4, 4'b0000,4'd5},  // R5
        '{1'b0,1'b0,1'b0,8'd2, 4'b0010,4'd9},  // R9 disabled
        '{1'b0,1'b1,1'b0,8'd12,4'b0010,4'd9},  // R9 host low ignored
        '{1'b0,1'b0,1'b0,8'd3, 4'b0010,4'd9},  // R9
        '{1'b1,1'b0,1'b0,8'd12,4'b0000,4'd9},  // R9 no spurious copy
        '{1'b1,1'b1,1'b0,8'd9, 4'b0010,4'd9},  // R9 works again
        '{1'b1,1'b0,1'b0,8'd9, 4'b0000,4'd6}   // R6
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic hd  = 1'b0;
    logic cd  = 1'b0;
    logic host_in, card_in;
    logic host_pull_low, host_boost, card_pull_low, card_boost;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #5 clk = ~clk;

    assign host_in = !(hd || host_pull_low);
    assign card_in = !(cd || card_pull_low);

    line_repeater #(.DELAY_CYC(D)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .host_in       (host_in),
        .card_in       (card_in),
        .host_pull_low (host_pull_low),
        .host_boost    (host_boost),
        .card_pull_low (card_pull_low),
        .card_boost    (card_boost)
    );

    task automatic check(input logic [3:0] exp, input int req);
        logic [3:0] act;
        act = {host_pull_low, host_boost, card_pull_low, card_boost};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d at %0t: outputs act=%b exp=%b", req, $time, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic h, input logic c, input int n,
                        input logic [3:0] exp, input int req);
        en = e; hd = h; cd = c;
        repeat (n) @(posedge clk);
        #1;
        check(exp, req);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check(4'b0000, 1);       // R1 reset state
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].en, VECS[i].hd, VECS[i].cd, int'(VECS[i].n),
                 VECS[i].exp, int'(VECS[i].req));
        end
        // R1: reset during an active copy clears the drives
        step(1'b1, 1'b1, 1'b0, D + 3, 4'b0010, 2);
        rst = 1'b1;
        step(1'b1, 1'b0, 1'b0, 1, 4'b0000, 1);
        step(1'b1, 1'b0, 1'b0, 3, 4'b0000, 1);
        rst = 1'b0;
        step(1'b1, 1'b0, 1'b0, 5, 4'b0000, 1);
        // R2 again after reset
        step(1'b1, 1'b1, 1'b0, D + 3, 4'b0010, 2);
        step(1'b1, 1'b0, 1'b0, D + 6, 4'b0000, 6);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule